// File: doc/BRIEF.md
# Instruction Field Decoder with Suffix Constants

This block takes a stream of 64-bit instruction words and splits each one into four 16-bit fields: opcode, src1, src2 and dest. For each field it reports the addressing mode, the cascade (emulation) bit and the special-space bit. It also reports the field's resolved value. Short values ride inside the field. A wider immediate is signalled by an all-ones payload in an immediate-mode field. That wider value is then taken from suffix words that follow the instruction in the stream.

When an instruction needs suffix constants, the decoder keeps it internally and consumes the following suffix words. It assigns them to the waiting fields in a fixed order. The decoded instruction is offered on the output only once every needed constant has arrived.

A suffix binds to the instruction just before it and is then discarded. Two cases are reported rather than hidden:
- If an ordinary instruction word shows up before all needed suffixes have arrived, the held instruction is emitted with a shortfall flag.
- If a suffix word arrives while no instruction is waiting for one, the word is dropped and a one-cycle pulse is raised.

Both stream edges are valid/ready. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. A decoded instruction leaves on an edge where `out_valid` and `out_ready` are both high. While the output holds an instruction that has not been taken, `in_ready` is low and the output stays unchanged. While suffixes are being gathered, `in_ready` is also low whenever the presented word is not a suffix word. That word is accepted only after the held instruction has been emitted.

Top module: `insn_field_decoder`

## Requirements
- R1: Field layout. The opcode field is word bits 63:48, src1 is 47:32, src2 is 31:16 and dest is 15:0. Within a field:
  - bits 1:0 hold the addressing mode (0 immediate, 1 direct, 2 indirect, 3 special);
  - bit 2 is the cascade bit;
  - bit 3 selects special space;
  - bits 15:4 are the 12-bit data.
  Outputs are indexed with opcode as field 0 and dest as field 3: field i mode at `out_mode[2i+1:2i]`, cascade at `out_casc[i]`, special at `out_spec[i]`, and value at `out_value[48i+47:48i]`.
- R2: A field that needs no suffix outputs its 12-bit data, zero-extended to 48 bits, as its value.
- R3: A field needs a suffix only if its mode is immediate and its data is 12'hFFF. A field whose data is 12'hFFF in any other mode outputs 12'hFFF and consumes nothing.
- R4: A suffix word is a word whose bits 63:48 equal 16'hFFFE. Its bits 47:0 are the constant. Suffix words fill the waiting fields in the order opcode, src1, src2, dest, one word per field.
- R5: While an instruction is still waiting for suffix words, `out_valid` stays low. `out_valid` rises on the clock edge that accepts the last needed suffix word.
- R6: If a non-suffix word is presented while suffixes are still missing, the held instruction is emitted with `out_short` high and value 0 for each unfilled field. The new word is not accepted in that cycle; it is accepted afterwards and decoded as an instruction.
- R7: A suffix word accepted while no instruction is waiting for one produces no output and raises `stray_err` for exactly one cycle.
- R8: A suffix constant is not retained. A later instruction that needs a constant takes it only from its own suffix words.
- R9: `out_custom` is high exactly when the opcode field is in immediate mode and its resolved value is 2048 or more, that is, in the upper half of the 12-bit opcode space or beyond.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and all outputs hold their values.
- R11: After reset, `out_valid` and `stray_err` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Decoder accepts the presented word |
| in_word | input | 64 | Instruction or suffix word |
| out_valid | output | 1 | Decoded instruction valid |
| out_ready | input | 1 | Consumer takes the decoded instruction |
| out_mode | output | 8 | Addressing mode per field, 2 bits each, opcode lowest |
| out_casc | output | 4 | Cascade bit per field |
| out_spec | output | 4 | Special-space bit per field |
| out_value | output | 192 | Resolved 48-bit value per field, opcode lowest |
| out_custom | output | 1 | Opcode is in the custom range |
| out_short | output | 1 | Instruction emitted with missing suffix constants |
| stray_err | output | 1 | One-cycle pulse when an unexpected suffix is dropped |

## Verification
The decoder is exercised with several input patterns, and each one separates a different mistake:
- Plain instructions with mixed modes and control bits catch swapped fields or misplaced control bits.
- All-ones data in non-immediate modes separates the sentinel rule from a plain payload compare.
- A single opcode suffix, all four suffixes, and a src2/dest-only pair each carry distinct constants, so a wrong fill order shows up as swapped values.
- A stray suffix, an early ordinary word during collection, and back-to-back suffixed instructions test dropping, the shortfall path and non-retention.
- A phase with a stalling consumer checks that the output holds and input stalls.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int CTL_W    = 4;
  localparam int MODE_LSB = 0;
  localparam int CASC_BIT = 2;
  localparam int SPEC_BIT = 3;
  localparam logic [1:0] AM_IMM = 2'd0;
  localparam logic [1:0] AM_DIR = 2'd1;
  localparam logic [1:0] AM_IND = 2'd2;
  localparam logic [1:0] AM_SPC = 2'd3;
endpackage

// File: rtl/idec_field_split.sv
module idec_field_split
  import idec_pkg::*;
#(
  parameter int DATA_W = 12,
  localparam int FLD_W = DATA_W + CTL_W
) (
  input  logic [FLD_W-1:0]  fld,
  output logic [1:0]        mode,
  output logic              casc,
  output logic              spec,
  output logic [DATA_W-1:0] data,
  output logic              need_sfx
);
  assign mode     = fld[MODE_LSB +: 2];
  assign casc     = fld[CASC_BIT];
  assign spec     = fld[SPEC_BIT];
  assign data     = fld[FLD_W-1:CTL_W];
  // an all-ones immediate payload points at a suffix word
  assign need_sfx = (mode == AM_IMM) && (&data);
endmodule

// File: rtl/idec_sfx_probe.sv
module idec_sfx_probe #(
  parameter int WORD_W = 64,
  parameter int TAG_W  = 16,
  parameter logic [TAG_W-1:0] TAG = '1,
  localparam int PAY_W = WORD_W - TAG_W
) (
  input  logic [WORD_W-1:0] word,
  output logic              is_sfx,
  output logic [PAY_W-1:0]  payload
);
  assign is_sfx  = (word[WORD_W-1 -: TAG_W] == TAG);
  assign payload = word[PAY_W-1:0];
endmodule

// File: rtl/idec_first_pend.sv
module idec_first_pend #(
  parameter int N = 4
) (
  input  logic [N-1:0] mask,
  output logic [N-1:0] pick,
  output logic         last
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_pick
    assign pick[i]   = mask[i] & ~seen[i];
    assign seen[i+1] = seen[i] | mask[i];
  end
  assign last = (|mask) && ((mask & (mask - 1'b1)) == '0);
endmodule

// File: rtl/insn_field_decoder.sv
module insn_field_decoder
  import idec_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int NF      = 4,
  parameter int SFX_TAG = 'hFFFE,
  localparam int FLD_W  = DATA_W + CTL_W,
  localparam int WORD_W = NF * FLD_W,
  localparam int VAL_W  = WORD_W - FLD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_W-1:0]   in_word,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [2*NF-1:0]     out_mode,
  output logic [NF-1:0]       out_casc,
  output logic [NF-1:0]       out_spec,
  output logic [NF*VAL_W-1:0] out_value,
  output logic                out_custom,
  output logic                out_short,
  output logic                stray_err
);
  localparam logic [FLD_W-1:0] TAG = FLD_W'(SFX_TAG);

  // field split of the presented word
  logic [1:0]        f_mode [NF];
  logic              f_casc [NF];
  logic              f_spec [NF];
  logic [DATA_W-1:0] f_data [NF];
  logic [NF-1:0]     need;

  for (genvar i = 0; i < NF; i++) begin : g_fld
    idec_field_split #(.DATA_W(DATA_W)) u_split (
      .fld      (in_word[(NF-1-i)*FLD_W +: FLD_W]),
      .mode     (f_mode[i]),
      .casc     (f_casc[i]),
      .spec     (f_spec[i]),
      .data     (f_data[i]),
      .need_sfx (need[i])
    );
  end

  logic             is_sfx;
  logic [VAL_W-1:0] payload;
  idec_sfx_probe #(.WORD_W(WORD_W), .TAG_W(FLD_W), .TAG(TAG)) u_probe (
    .word    (in_word),
    .is_sfx  (is_sfx),
    .payload (payload)
  );

  // held instruction while suffix words are gathered
  logic [NF-1:0]    mask_q;
  logic [1:0]       p_mode [NF];
  logic             p_casc [NF];
  logic             p_spec [NF];
  logic [VAL_W-1:0] p_val  [NF];

  logic [NF-1:0] pick;
  logic          last;
  idec_first_pend #(.N(NF)) u_pend (
    .mask (mask_q),
    .pick (pick),
    .last (last)
  );

  // output slot
  logic [1:0]       o_mode [NF];
  logic             o_casc [NF];
  logic             o_spec [NF];
  logic [VAL_W-1:0] o_val  [NF];

  logic collecting, slot_free, fire, abort;
  assign collecting = |mask_q;
  assign slot_free  = !out_valid || out_ready;
  assign in_ready   = slot_free && !(collecting && !is_sfx);
  assign fire       = in_valid && in_ready;
  assign abort      = collecting && in_valid && !is_sfx && slot_free;

  logic             emit_new, emit_fill, emit;
  logic [VAL_W-1:0] new_val  [NF];
  logic [VAL_W-1:0] fill_val [NF];
  logic [1:0]       e_mode   [NF];
  logic             e_casc   [NF];
  logic             e_spec   [NF];
  logic [VAL_W-1:0] e_val    [NF];
  logic             e_custom;

  assign emit_new  = fire && !collecting && !is_sfx && (need == '0);
  assign emit_fill = fire && collecting && last;
  assign emit      = emit_new || emit_fill || abort;

  always_comb begin
    for (int i = 0; i < NF; i++) begin
      new_val[i]  = need[i] ? '0 : VAL_W'(f_data[i]);
      fill_val[i] = (fire && pick[i]) ? payload : p_val[i];
      e_mode[i]   = emit_new ? f_mode[i] : p_mode[i];
      e_casc[i]   = emit_new ? f_casc[i] : p_casc[i];
      e_spec[i]   = emit_new ? f_spec[i] : p_spec[i];
      e_val[i]    = emit_new ? new_val[i] : fill_val[i];
    end
    e_custom = (e_mode[0] == AM_IMM) && (|e_val[0][VAL_W-1:DATA_W-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_custom <= 1'b0;
      out_short  <= 1'b0;
      stray_err  <= 1'b0;
      mask_q     <= '0;
      for (int i = 0; i < NF; i++) begin
        p_mode[i] <= '0;
        p_casc[i] <= 1'b0;
        p_spec[i] <= 1'b0;
        p_val[i]  <= '0;
        o_mode[i] <= '0;
        o_casc[i] <= 1'b0;
        o_spec[i] <= 1'b0;
        o_val[i]  <= '0;
      end
    end else begin
      stray_err <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;

      if (emit) begin
        out_valid  <= 1'b1;
        out_custom <= e_custom;
        out_short  <= abort;
        for (int i = 0; i < NF; i++) begin
          o_mode[i] <= e_mode[i];
          o_casc[i] <= e_casc[i];
          o_spec[i] <= e_spec[i];
          o_val[i]  <= e_val[i];
        end
      end

      if (abort) begin
        mask_q <= '0;
      end else if (fire) begin
        if (collecting) begin
          mask_q <= mask_q & ~pick;
          for (int i = 0; i < NF; i++) p_val[i] <= fill_val[i];
        end else if (is_sfx) begin
          stray_err <= 1'b1;
        end else if (need != '0) begin
          mask_q <= need;
          for (int i = 0; i < NF; i++) begin
            p_mode[i] <= f_mode[i];
            p_casc[i] <= f_casc[i];
            p_spec[i] <= f_spec[i];
            p_val[i]  <= new_val[i];
          end
        end
      end
    end
  end

  for (genvar i = 0; i < NF; i++) begin : g_out
    assign out_mode[2*i +: 2]       = o_mode[i];
    assign out_casc[i]              = o_casc[i];
    assign out_spec[i]              = o_spec[i];
    assign out_value[i*VAL_W +: VAL_W] = o_val[i];
  end
endmodule

// File: rtl/insn_field_decoder_chk.sv
module insn_field_decoder_chk #(
  parameter int NF     = 4,
  parameter int FLD_W  = 16,
  parameter int WORD_W = 64,
  parameter int VAL_W  = 48,
  parameter logic [FLD_W-1:0] TAG = '1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [WORD_W-1:0]   in_word,
  input logic                out_valid,
  input logic                out_ready,
  input logic [2*NF-1:0]     out_mode,
  input logic [NF*VAL_W-1:0] out_value,
  input logic                out_custom,
  input logic                stray_err,
  input logic [NF-1:0]       mask_q
);
  logic sfx_in;
  assign sfx_in = (in_word[WORD_W-1 -: FLD_W] == TAG);

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_value) && $stable(out_mode)); // R10

  AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R10

  AST_STRAY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && sfx_in && (mask_q == '0) |=> stray_err); // R7

  AST_STRAY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && sfx_in && (mask_q == '0) && !out_valid |=> !out_valid); // R7

  AST_COLLECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && ($countones(mask_q) > 1) && !out_valid |=> !out_valid); // R5

  AST_SFX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (mask_q != '0)
    |=> $countones(mask_q) == $countones($past(mask_q)) - 1); // R4

  AST_CUSTOM_IMM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_custom |-> out_mode[1:0] == 2'd0); // R9
endmodule

bind insn_field_decoder insn_field_decoder_chk #(
  .NF(NF), .FLD_W(FLD_W), .WORD_W(WORD_W), .VAL_W(VAL_W), .TAG(TAG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
  .out_mode(out_mode), .out_value(out_value), .out_custom(out_custom),
  .stray_err(stray_err), .mask_q(mask_q)
);

// File: tb/test_insn_field_decoder.sv
module test_insn_field_decoder;
  localparam int EW = 2 + 8 + 4 + 4 + 192;
  localparam logic [15:0] TAG = 16'hFFFE;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [63:0]  in_word = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [7:0]   out_mode;
  logic [3:0]   out_casc;
  logic [3:0]   out_spec;
  logic [191:0] out_value;
  logic         out_custom;
  logic         out_short;
  logic         stray_err;

  always #5 clk = ~clk;

  insn_field_decoder i_insn_field_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_mode(out_mode), .out_casc(out_casc), .out_spec(out_spec),
    .out_value(out_value), .out_custom(out_custom), .out_short(out_short),
    .stray_err(stray_err)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  bit bp_mode = 0;
  int cyc = 0;
  logic [EW-1:0] exp_q [$];
  string         tag_q [$];

  function automatic logic [15:0] fl(input logic [11:0] d, input logic [1:0] m,
                                     input logic c, input logic s);
    return {d, s, c, m};
  endfunction

  // expected decode built from the requirements
  function automatic logic [EW-1:0] mk(input logic [63:0] w, input logic [191:0] p, input int avail);
    logic [191:0] v = '0;
    logic [7:0] m = '0;
    logic [3:0] c = '0;
    logic [3:0] s = '0;
    logic sh = 1'b0;
    logic cu;
    int k = 0;
    for (int i = 0; i < 4; i++) begin
      logic [15:0] f;
      f = w[(3-i)*16 +: 16];
      m[2*i +: 2] = f[1:0];
      c[i] = f[2];
      s[i] = f[3];
      if (f[1:0] == 2'd0 && f[15:4] == 12'hFFF) begin
        if (k < avail) v[i*48 +: 48] = p[k*48 +: 48];
        else sh = 1'b1;
        k++;
      end else begin
        v[i*48 +: 48] = {36'd0, f[15:4]};
      end
    end
    cu = (m[1:0] == 2'd0) && (v[47:0] >= 48'd2048);
    return {cu, sh, m, c, s, v};
  endfunction

  task automatic check(input bit ok, input string req, input logic [191:0] act, input logic [191:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_word(input logic [63:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic send(input logic [63:0] w, input logic [191:0] p, input int nprov, input string req);
    exp_q.push_back(mk(w, p, nprov));
    tag_q.push_back(req);
    put_word(w);
    for (int k = 0; k < nprov; k++) put_word({TAG, p[k*48 +: 48]});
  endtask

  // consumer pattern, changed away from the edges
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #3 out_ready = !bp_mode || (cyc % 3 == 0);
  end

  // monitor: compare at each handshake
  always @(negedge clk) begin
    if (rst_n && out_valid && !out_ready)
      check(in_ready == 1'b0, "R10", {191'd0, in_ready}, 192'd0);
    if (rst_n && out_valid && out_ready) begin
      logic [EW-1:0] act;
      act = {out_custom, out_short, out_mode, out_casc, out_spec, out_value};
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", act[191:0], 192'd0);
      end else begin
        logic [EW-1:0] e;
        string r;
        e = exp_q.pop_front();
        r = tag_q.pop_front();
        check(act == e, r, act[191:0], e[191:0]);
        check(act[EW-1:192] == e[EW-1:192], r, {174'd0, act[EW-1:192]}, {174'd0, e[EW-1:192]});
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [63:0] w;
    logic [191:0] p;
    // R11 reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && stray_err == 1'b0, "R11", {190'd0, out_valid, stray_err}, 192'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R11", {191'd0, in_ready}, 192'd1);

    // R1 R2: mixed modes and control bits
    w = {fl(12'h012, 2'd0, 1'b0, 1'b0), fl(12'h345, 2'd1, 1'b1, 1'b0),
         fl(12'h678, 2'd2, 1'b0, 1'b1), fl(12'h9AB, 2'd3, 1'b1, 1'b1)};
    send(w, '0, 0, "R1");
    w = {fl(12'h5A5, 2'd3, 1'b1, 1'b0), fl(12'h001, 2'd0, 1'b1, 1'b1),
         fl(12'hABC, 2'd1, 1'b0, 1'b1), fl(12'h000, 2'd0, 1'b0, 1'b0)};
    send(w, '0, 0, "R2");

    // R3: all-ones data outside immediate mode, R9 top of built-in range
    w = {fl(12'h7FF, 2'd0, 1'b0, 1'b0), fl(12'hFFF, 2'd1, 1'b0, 1'b0),
         fl(12'hFFF, 2'd2, 1'b1, 1'b0), fl(12'hFFF, 2'd3, 1'b0, 1'b1)};
    send(w, '0, 0, "R3");
    // R9: lowest custom opcode
    w = {fl(12'h800, 2'd0, 1'b0, 1'b0), fl(12'h001, 2'd0, 1'b0, 1'b0),
         fl(12'h002, 2'd0, 1'b0, 1'b0), fl(12'h003, 2'd1, 1'b0, 1'b0)};
    send(w, '0, 0, "R9");

    // R4 R9: opcode from a suffix word
    w = {fl(12'hFFF, 2'd0, 1'b0, 1'b0), fl(12'h011, 2'd1, 1'b0, 1'b0),
         fl(12'h022, 2'd2, 1'b0, 1'b0), fl(12'h033, 2'd3, 1'b0, 1'b0)};
    p = '0; p[47:0] = 48'h0000_0000_1234;
    send(w, p, 1, "R4");

    // R5 R4: four suffixes, output only after the last
    w = {fl(12'hFFF, 2'd0, 1'b1, 1'b0), fl(12'hFFF, 2'd0, 1'b0, 1'b1),
         fl(12'hFFF, 2'd0, 1'b1, 1'b1), fl(12'hFFF, 2'd0, 1'b0, 1'b0)};
    p = {48'hDDDD_0000_0004, 48'hCCCC_0000_0003, 48'hBBBB_0000_0002, 48'h0000_0000_0101};
    exp_q.push_back(mk(w, p, 4));
    tag_q.push_back("R4");
    put_word(w);
    @(negedge clk);
    check(out_valid == 1'b0, "R5", {191'd0, out_valid}, 192'd0);
    for (int k = 0; k < 3; k++) begin
      put_word({TAG, p[k*48 +: 48]});
      @(negedge clk);
      check(out_valid == 1'b0, "R5", {191'd0, out_valid}, 192'd0);
    end
    put_word({TAG, p[3*48 +: 48]});
    @(negedge clk);
    check(out_valid == 1'b1, "R5", {191'd0, out_valid}, 192'd1);

    // R4: only src2 and dest take suffixes, in that order
    w = {fl(12'h00A, 2'd1, 1'b0, 1'b0), fl(12'h00B, 2'd0, 1'b0, 1'b0),
         fl(12'hFFF, 2'd0, 1'b0, 1'b0), fl(12'hFFF, 2'd0, 1'b1, 1'b0)};
    p = '0; p[47:0] = 48'h1111_2222_3333; p[95:48] = 48'h4444_5555_6666;
    send(w, p, 2, "R4");

    // R7: stray suffix word
    put_word({TAG, 48'h0000_0000_0777});
    @(negedge clk);
    check(stray_err == 1'b1, "R7", {191'd0, stray_err}, 192'd1);
    check(out_valid == 1'b0, "R7", {191'd0, out_valid}, 192'd0);
    @(negedge clk);
    check(stray_err == 1'b0, "R7", {191'd0, stray_err}, 192'd0);

    // R8: back-to-back suffixed instructions, each with its own constant
    w = {fl(12'h010, 2'd0, 1'b0, 1'b0), fl(12'hFFF, 2'd0, 1'b0, 1'b0),
         fl(12'h001, 2'd1, 1'b0, 1'b0), fl(12'h002, 2'd1, 1'b0, 1'b0)};
    p = '0; p[47:0] = 48'h0000_00AB_CDEF;
    send(w, p, 1, "R8");
    p = '0; p[47:0] = 48'h0000_0000_0042;
    send(w, p, 1, "R8");

    // R6: one of two suffixes supplied, then an ordinary word
    w = {fl(12'h020, 2'd0, 1'b0, 1'b0), fl(12'hFFF, 2'd0, 1'b0, 1'b0),
         fl(12'h003, 2'd2, 1'b0, 1'b0), fl(12'hFFF, 2'd0, 1'b0, 1'b1)};
    p = '0; p[47:0] = 48'h0000_0000_5555;
    send(w, p, 1, "R6");
    w = {fl(12'h030, 2'd0, 1'b0, 1'b0), fl(12'h004, 2'd3, 1'b1, 1'b1),
         fl(12'h005, 2'd1, 1'b0, 1'b0), fl(12'h006, 2'd2, 1'b0, 1'b0)};
    send(w, '0, 0, "R6");

    // R10: stalling consumer
    bp_mode = 1;
    for (int n = 0; n < 6; n++) begin
      w = {fl(12'(n + 12'h100), 2'd0, 1'b0, 1'b0), fl(12'hFFF, 2'd0, 1'b0, 1'b0),
           fl(12'(n), 2'd1, 1'(n), 1'b0), fl(12'h00F, 2'(n), 1'b0, 1'(n))};
      p = '0; p[47:0] = 48'(n * 1000 + 7);
      send(w, p, 1, "R10");
    end
    w = {fl(12'h900, 2'd0, 1'b1, 1'b0), fl(12'h001, 2'd1, 1'b0, 1'b0),
         fl(12'h002, 2'd2, 1'b0, 1'b0), fl(12'h003, 2'd3, 1'b0, 1'b0)};
    send(w, '0, 0, "R10");

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R5", 192'(exp_q.size()), 192'd0);
    done = 1;
    finish_run();
  end
endmodule